// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between the host-side data register of a serial port and its bit-level framer. It steers bytes among four places: the host data register, a receive FIFO, a transmit FIFO and the serial line. A 2-bit channel-mode input selects the routing. A 9-bit control register holds enable and disable bits for each direction, two soft-reset bits that clear themselves, and two break-request bits that are stored for the framer.

The framer hands in received bytes one at a time with a one-cycle strobe. It takes transmit bytes through a valid/ready handshake. Serial bit framing is not part of this block.

Bytes can be lost at a full FIFO, and the block reports this with one-cycle overrun pulses. When the line goes quiet, a receive-idle timer raises a one-cycle timeout pulse after four character times, where each character time is a fixed number of clock cycles. The timer is a small state machine with three states: `TMR_IDLE` (not armed), `TMR_RUN` (counting down) and `TMR_FIRE` (pulse cycle). Its transitions are:
- IDLE→RUN on an accepted receive byte.
- RUN→RUN (reload) on a further accepted byte.
- RUN→FIRE when the count reaches zero.
- FIRE→IDLE, or FIRE→RUN if a byte arrives in that cycle.
- Any state→IDLE on a receive soft reset.

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control value `ctrl_o` reads 0x128 (bits 3, 5 and 8 set), both FIFO counts are zero, and `line_tx_valid`, `rx_overrun`, `tx_overrun` and `rx_timeout` are low.
- R2: With `mode`=0 (normal), a host write enters the TX FIFO and a line byte enters the RX FIFO. The line drains the TX FIFO oldest-first through `line_tx_valid`/`line_tx_ready`.
- R3: With `mode`=1 (echo), a line byte enters both the RX and the TX FIFO, and host writes are discarded.
- R4: With `mode`=2 (local loopback), a host write enters the RX FIFO, and line bytes are discarded.
- R5: With `mode`=3 (remote loopback), a line byte enters the TX FIFO only, and host writes are discarded.
- R6: The receive side is on only when control bit 2 (RX enable) is 1 and bit 3 (RX disable) is 0. While it is off, RX FIFO writes are ignored, and host reads return 0 without popping.
- R7: The transmit side accepts bytes only when control bit 4 (TX enable) is 1 and bit 5 (TX disable) is 0. Otherwise TX FIFO writes are ignored.
- R8: A byte for a full RX FIFO (DEPTH entries) is dropped, and `rx_overrun` is high for exactly the one cycle after the edge that dropped it.
- R9: A byte for a full TX FIFO is dropped, and `tx_overrun` is high for the one cycle after that edge.
- R10: A control write with bit 0 set empties the RX FIFO, and one with bit 1 set empties the TX FIFO. Both bits always read back as 0 in `ctrl_o`.
- R11: Host reads return RX bytes oldest-first on `host_rdata` one cycle after `host_rd`. A read of an empty RX FIFO returns 0 and leaves the count at 0.
- R12: Each accepted RX byte (re)starts a window of TO_CHARS×CHAR_CYCLES clock cycles. If no further byte is accepted, `rx_timeout` is high for the single cycle after the edge that ends the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Channel mode: 0 normal, 1 echo, 2 local loopback, 3 remote loopback |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 9 | Control write value |
| ctrl_o | output | 9 | Current control register value |
| host_wr | input | 1 | Host data-register write strobe |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host data-register read strobe |
| host_rdata | output | 8 | Read result, valid the cycle after host_rd |
| line_rx_valid | input | 1 | Byte received from the line |
| line_rx_data | input | 8 | Received byte |
| line_tx_valid | output | 1 | TX FIFO holds a byte for the line |
| line_tx_data | output | 8 | Oldest TX byte |
| line_tx_ready | input | 1 | Line takes the TX byte this cycle |
| rx_count | output | $clog2(DEPTH+1) | RX FIFO occupancy |
| tx_count | output | $clog2(DEPTH+1) | TX FIFO occupancy |
| rx_overrun | output | 1 | One-cycle RX overflow pulse |
| tx_overrun | output | 1 | One-cycle TX overflow pulse |
| rx_timeout | output | 1 | One-cycle receive-idle pulse |

## Verification
A corrupted pointer or occupancy count shows up within one access. The next host read or line drain returns a byte out of order, or the count port disagrees with the number of accepted bytes. A wrong routing decode shows up one cycle after the stimulus, as a count that rises on the wrong FIFO. A timer stuck in the wrong state shows as a timeout pulse that is missing, comes early, or lasts more than one cycle. The bench therefore walks the exact window edge, cycle by cycle.

// File: rtl/uart_router_pkg.sv
package uart_router_pkg;
    typedef enum logic [1:0] {
        CHM_NORMAL = 2'd0,
        CHM_ECHO   = 2'd1,
        CHM_LOCAL  = 2'd2,
        CHM_REMOTE = 2'd3
    } chan_mode_e;

    typedef enum logic [1:0] {
        TMR_IDLE = 2'd0,
        TMR_RUN  = 2'd1,
        TMR_FIRE = 2'd2
    } tmr_state_e;

    localparam int CTL_W        = 9;
    localparam int CTL_RX_RST   = 0;
    localparam int CTL_TX_RST   = 1;
    localparam int CTL_RX_EN    = 2;
    localparam int CTL_RX_DIS   = 3;
    localparam int CTL_TX_EN    = 4;
    localparam int CTL_TX_DIS   = 5;
    localparam logic [CTL_W-1:0] CTL_RESET = 9'h128;
endpackage

// File: rtl/router_fifo.sv
module router_fifo #(
    parameter int DEPTH = 64,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full && !clear;
    assign do_pop  = pop && !empty && !clear;
    assign dout    = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clear) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/chan_steer.sv
module chan_steer
    import uart_router_pkg::*;
(
    input  logic [1:0] mode,
    output logic       line_to_rx,
    output logic       line_to_tx,
    output logic       host_to_rx,
    output logic       host_to_tx
);
    chan_mode_e m;
    assign m = chan_mode_e'(mode);

    always_comb begin
        line_to_rx = 1'b0;
        line_to_tx = 1'b0;
        host_to_rx = 1'b0;
        host_to_tx = 1'b0;
        unique case (m)
            CHM_NORMAL: begin line_to_rx = 1'b1; host_to_tx = 1'b1; end
            CHM_ECHO:   begin line_to_rx = 1'b1; line_to_tx = 1'b1; end
            CHM_LOCAL:  host_to_rx = 1'b1;
            CHM_REMOTE: line_to_tx = 1'b1;
        endcase
    end
endmodule

// File: rtl/rx_idle_timer.sv
module rx_idle_timer
    import uart_router_pkg::*;
#(
    parameter int LIMIT = 64,
    localparam int TW   = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    input  logic cancel,
    output logic expired
);
    tmr_state_e    state, state_n;
    logic [TW-1:0] cnt, cnt_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= TMR_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            TMR_IDLE: if (kick) begin
                state_n = TMR_RUN;
                cnt_n   = TW'(LIMIT - 1);
            end
            TMR_RUN: if (kick) begin
                cnt_n = TW'(LIMIT - 1);
            end else if (cnt == '0) begin
                state_n = TMR_FIRE;
            end else begin
                cnt_n = cnt - TW'(1);
            end
            TMR_FIRE: if (kick) begin
                state_n = TMR_RUN;
                cnt_n   = TW'(LIMIT - 1);
            end else begin
                state_n = TMR_IDLE;
            end
            default: state_n = TMR_IDLE;
        endcase
        if (cancel) state_n = TMR_IDLE;
    end

    always_comb begin
        expired = (state == TMR_FIRE);
    end
endmodule

// File: rtl/uart_chan_router.sv
module uart_chan_router
    import uart_router_pkg::*;
#(
    parameter int DEPTH       = 64,
    parameter int CHAR_CYCLES = 16,
    parameter int TO_CHARS    = 4,
    localparam int CW         = $clog2(DEPTH + 1),
    localparam int LIMIT      = TO_CHARS * CHAR_CYCLES
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode,
    input  logic             cfg_wr,
    input  logic [CTL_W-1:0] cfg_wdata,
    output logic [CTL_W-1:0] ctrl_o,
    input  logic             host_wr,
    input  logic [7:0]       host_wdata,
    input  logic             host_rd,
    output logic [7:0]       host_rdata,
    input  logic             line_rx_valid,
    input  logic [7:0]       line_rx_data,
    output logic             line_tx_valid,
    output logic [7:0]       line_tx_data,
    input  logic             line_tx_ready,
    output logic [CW-1:0]    rx_count,
    output logic [CW-1:0]    tx_count,
    output logic             rx_overrun,
    output logic             tx_overrun,
    output logic             rx_timeout
);
    logic [CTL_W-1:0] ctrl_q;
    logic rx_on, tx_on, rx_clear, tx_clear;
    logic line_to_rx, line_to_tx, host_to_rx, host_to_tx;
    logic rx_req, tx_req, rx_push, tx_push, rx_pop, tx_pop;
    logic rx_full, rx_empty, tx_full, tx_empty;
    logic [7:0] rx_din, tx_din, rx_head;

    // control register: soft-reset bits never stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      ctrl_q <= CTL_RESET;
        else if (cfg_wr) ctrl_q <= cfg_wdata & ~(CTL_W'(1) << CTL_RX_RST) & ~(CTL_W'(1) << CTL_TX_RST);
    end
    assign ctrl_o   = ctrl_q;
    assign rx_on    = ctrl_q[CTL_RX_EN] && !ctrl_q[CTL_RX_DIS];
    assign tx_on    = ctrl_q[CTL_TX_EN] && !ctrl_q[CTL_TX_DIS];
    assign rx_clear = cfg_wr && cfg_wdata[CTL_RX_RST];
    assign tx_clear = cfg_wr && cfg_wdata[CTL_TX_RST];

    chan_steer steer_i (
        .mode       (mode),
        .line_to_rx (line_to_rx),
        .line_to_tx (line_to_tx),
        .host_to_rx (host_to_rx),
        .host_to_tx (host_to_tx)
    );

    assign rx_req  = rx_on && !rx_clear &&
                     ((line_rx_valid && line_to_rx) || (host_wr && host_to_rx));
    assign tx_req  = tx_on && !tx_clear &&
                     ((line_rx_valid && line_to_tx) || (host_wr && host_to_tx));
    assign rx_push = rx_req && !rx_full;
    assign tx_push = tx_req && !tx_full;
    assign rx_pop  = host_rd && rx_on && !rx_empty && !rx_clear;
    assign tx_pop  = line_tx_ready && !tx_empty && !tx_clear;
    assign rx_din  = host_to_rx ? host_wdata : line_rx_data;
    assign tx_din  = host_to_tx ? host_wdata : line_rx_data;

    router_fifo #(.DEPTH(DEPTH), .DW(8)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear), .push(rx_push), .pop(rx_pop),
        .din(rx_din), .dout(rx_head), .count(rx_count), .full(rx_full), .empty(rx_empty)
    );

    router_fifo #(.DEPTH(DEPTH), .DW(8)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n), .clear(tx_clear), .push(tx_push), .pop(tx_pop),
        .din(tx_din), .dout(line_tx_data), .count(tx_count), .full(tx_full), .empty(tx_empty)
    );

    assign line_tx_valid = !tx_empty;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            host_rdata <= '0;
            rx_overrun <= 1'b0;
            tx_overrun <= 1'b0;
        end else begin
            if (host_rd) host_rdata <= rx_pop ? rx_head : 8'h00;
            rx_overrun <= rx_req && rx_full;
            tx_overrun <= tx_req && tx_full;
        end
    end

    rx_idle_timer #(.LIMIT(LIMIT)) timer_i (
        .clk(clk), .rst_n(rst_n), .kick(rx_push), .cancel(rx_clear), .expired(rx_timeout)
    );
endmodule

// File: rtl/uart_chan_router_chk.sv
module uart_chan_router_chk #(
    parameter int DEPTH = 64,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_wr,
    input logic [8:0]    cfg_wdata,
    input logic [8:0]    ctrl_o,
    input logic          host_rd,
    input logic [7:0]    host_rdata,
    input logic [CW-1:0] rx_count,
    input logic [CW-1:0] tx_count,
    input logic          rx_overrun,
    input logic          tx_overrun,
    input logic          rx_timeout
);
    assert_rx_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));
    assert_ovr_only_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_overrun) |-> $past(rx_count) == CW'(DEPTH));
    assert_tx_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_count <= CW'(DEPTH));
    assert_txovr_only_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_overrun) |-> $past(tx_count) == CW'(DEPTH));
    assert_rx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[0]) |=> rx_count == '0);
    assert_tx_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_wdata[1]) |=> tx_count == '0);
    assert_rst_bits_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_o[1:0] == 2'b00);
    assert_rx_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((!ctrl_o[2] || ctrl_o[3]) && !cfg_wr) |=> $stable(rx_count));
    assert_empty_read_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && rx_count == '0) |=> host_rdata == 8'h00);
    assert_timeout_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |=> !rx_timeout);
endmodule

bind uart_chan_router uart_chan_router_chk #(.DEPTH(DEPTH)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .ctrl_o(ctrl_o),
    .host_rd(host_rd), .host_rdata(host_rdata), .rx_count(rx_count), .tx_count(tx_count),
    .rx_overrun(rx_overrun), .tx_overrun(tx_overrun), .rx_timeout(rx_timeout)
);

// File: tb/uart_chan_router_tb_top.sv
module uart_chan_router_tb_top;
    localparam int DEPTH = 64;
    localparam int CHARC = 16;
    localparam int TOC   = 4;
    localparam int LIM   = CHARC * TOC;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [1:0] mode = 2'd0;
    logic cfg_wr = 1'b0;
    logic [8:0] cfg_wdata = '0;
    logic [8:0] ctrl_o;
    logic host_wr = 1'b0;
    logic [7:0] host_wdata = '0;
    logic host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic line_rx_valid = 1'b0;
    logic [7:0] line_rx_data = '0;
    logic line_tx_valid;
    logic [7:0] line_tx_data;
    logic line_tx_ready = 1'b0;
    logic [CW-1:0] rx_count, tx_count;
    logic rx_overrun, tx_overrun, rx_timeout;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [7:0] tx_q[$];
    logic [7:0] rx_q[$];

    always #10 clk = ~clk;

    uart_chan_router #(.DEPTH(DEPTH), .CHAR_CYCLES(CHARC), .TO_CHARS(TOC)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode(mode), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .ctrl_o(ctrl_o), .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .line_rx_valid(line_rx_valid), .line_rx_data(line_rx_data),
        .line_tx_valid(line_tx_valid), .line_tx_data(line_tx_data),
        .line_tx_ready(line_tx_ready), .rx_count(rx_count), .tx_count(tx_count),
        .rx_overrun(rx_overrun), .tx_overrun(tx_overrun), .rx_timeout(rx_timeout)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor for the line side
    always @(negedge clk) begin
        if (rst_n && line_tx_valid && line_tx_ready) begin
            if (tx_q.size() == 0) chk(1'b0, "R2 tx unexpected byte", line_tx_data, 0);
            else begin
                logic [7:0] e;
                e = tx_q.pop_front();
                chk(line_tx_data == e, "R2 tx order", line_tx_data, e);
            end
        end
    end

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic ctl(input logic [8:0] v);
        step(); cfg_wr = 1'b1; cfg_wdata = v;
        step(); cfg_wr = 1'b0;
    endtask

    task automatic hwr(input logic [7:0] b);
        step(); host_wr = 1'b1; host_wdata = b;
        step(); host_wr = 1'b0;
    endtask

    task automatic lrx(input logic [7:0] b);
        step(); line_rx_valid = 1'b1; line_rx_data = b;
        step(); line_rx_valid = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] exp, input string req);
        step(); host_rd = 1'b1;
        step(); host_rd = 1'b0;
        chk(host_rdata == exp, req, host_rdata, exp);
    endtask

    task automatic drain(input string req);
        int n;
        n = tx_q.size();
        step(); line_tx_ready = 1'b1;
        repeat (n + 2) step();
        line_tx_ready = 1'b0;
        chk(tx_q.size() == 0 && tx_count == 0, req, tx_count, 0);
    endtask

    initial begin
        #(20 * 150000);
        chk(1'b0, "watchdog", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        step();
        // R1 reset state
        chk(ctrl_o == 9'h128, "R1 ctrl", ctrl_o, 9'h128);
        chk(rx_count == 0 && tx_count == 0 && !line_tx_valid, "R1 counts", rx_count + tx_count, 0);
        chk(!rx_overrun && !tx_overrun && !rx_timeout, "R1 pulses", rx_overrun, 0);

        // disabled after reset: R6, R7
        lrx(8'h11); hwr(8'h22);
        chk(rx_count == 0, "R6 rx disabled", rx_count, 0);
        chk(tx_count == 0, "R7 tx disabled", tx_count, 0);
        hrd(8'h00, "R6 read while off");

        ctl(9'h114);
        chk(ctrl_o == 9'h114, "R10 ctrl write", ctrl_o, 9'h114);

        // R2 normal
        mode = 2'd0;
        hwr(8'hA1); tx_q.push_back(8'hA1);
        hwr(8'hA2); tx_q.push_back(8'hA2);
        lrx(8'hB1); lrx(8'hB2);
        chk(rx_count == 2 && tx_count == 2, "R2 counts", {rx_count, tx_count}, 0);
        hrd(8'hB1, "R11 oldest first");
        hrd(8'hB2, "R11 second");
        hrd(8'h00, "R11 empty read");
        chk(rx_count == 0, "R11 empty stays", rx_count, 0);
        drain("R2 drain");

        // R3 echo
        mode = 2'd1;
        lrx(8'hC1); tx_q.push_back(8'hC1);
        hwr(8'hD1);
        chk(rx_count == 1 && tx_count == 1, "R3 both fifos", {rx_count, tx_count}, 0);
        hrd(8'hC1, "R3 rx byte");
        drain("R3 drain");

        // R4 local loopback
        mode = 2'd2;
        hwr(8'hE1); hwr(8'hE2); lrx(8'hF1);
        chk(rx_count == 2 && tx_count == 0, "R4 routing", {rx_count, tx_count}, 0);
        hrd(8'hE1, "R4 first"); hrd(8'hE2, "R4 second");

        // R5 remote loopback
        mode = 2'd3;
        lrx(8'h51); tx_q.push_back(8'h51); hwr(8'h52);
        chk(rx_count == 0 && tx_count == 1, "R5 routing", {rx_count, tx_count}, 0);
        drain("R5 drain");

        // R6 disable overrides enable
        mode = 2'd0;
        lrx(8'h61);
        ctl(9'h11C);
        lrx(8'h62);
        chk(rx_count == 1, "R6 dis wins", rx_count, 1);
        hrd(8'h00, "R6 read blocked");
        chk(rx_count == 1, "R6 no pop", rx_count, 1);
        ctl(9'h114);
        hrd(8'h61, "R6 kept byte");

        // R7 tx disable overrides enable
        ctl(9'h134);
        hwr(8'h71);
        chk(tx_count == 0, "R7 dis wins", tx_count, 0);
        ctl(9'h114);

        // R8 rx overflow
        for (int i = 0; i < DEPTH; i++) lrx(8'(i + 8'h80));
        chk(rx_count == CW'(DEPTH) && !rx_overrun, "R8 full", rx_count, DEPTH);
        lrx(8'hEE);
        chk(rx_overrun == 1'b1, "R8 overrun pulse", rx_overrun, 1);
        chk(rx_count == CW'(DEPTH), "R8 dropped", rx_count, DEPTH);
        step();
        chk(rx_overrun == 1'b0, "R8 one cycle", rx_overrun, 0);
        hrd(8'h80, "R8 oldest kept");
        ctl(9'h115);
        chk(rx_count == 0 && ctrl_o == 9'h114, "R10 rx flush", rx_count, 0);

        // R9 tx overflow
        for (int i = 0; i < DEPTH; i++) hwr(8'(i));
        hwr(8'hFF);
        chk(tx_overrun == 1'b1 && tx_count == CW'(DEPTH), "R9 overrun", tx_overrun, 1);
        step();
        chk(tx_overrun == 1'b0, "R9 one cycle", tx_overrun, 0);
        ctl(9'h116);
        chk(tx_count == 0 && ctrl_o == 9'h114 && !line_tx_valid, "R10 tx flush", tx_count, 0);
        ctl(9'h115);

        // R12 timeout window and re-arm
        lrx(8'h90);
        begin
            bit early = 1'b0;
            for (int j = 1; j < LIM; j++) begin step(); if (rx_timeout) early = 1'b1; end
            chk(!early, "R12 no early", early, 0);
        end
        step(); chk(rx_timeout == 1'b1, "R12 fires", rx_timeout, 1);
        step(); chk(rx_timeout == 1'b0, "R12 one cycle", rx_timeout, 0);
        lrx(8'h91);
        repeat (LIM / 2) step();
        lrx(8'h92);
        begin
            bit early = 1'b0;
            for (int j = 1; j < LIM; j++) begin step(); if (rx_timeout) early = 1'b1; end
            chk(!early, "R12 rearm holds", early, 0);
        end
        step(); chk(rx_timeout == 1'b1, "R12 rearm fires", rx_timeout, 1);

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule